// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Controller

This block is the front end of a byte-wide parallel NOR-style flash memory, written as a synchronous model sampled on a system clock. Three active-low strobes (chip enable, output enable, write enable), an address and a split data bus come in. The block classifies every clock as one of these bus cycles: read, write, standby, output-disable, or contention (both output enable and write enable low).

Writes never touch the array directly. Each write cycle is captured once, at its first clock, into a command sequencer. That sequencer recognises unlock, identification, program, sector-erase and chip-erase sequences. The data returned by a read depends on the sequencer's mode:

- **Array contents** after reset and between operations.
- **Identification codes** after the identification sequence.
- **Status byte** while a program or erase is pending or running.

Program and erase take a fixed number of clock cycles, counted by a busy timer. The array is modelled as eight uniform sectors chosen by address bits 18:16. Each sector keeps `2**OFF_W` bytes, indexed by the low address bits; other address bits alias.

Top module: `flash_bus_ctrl`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1, so the bus is never driven during a write cycle or a contention cycle.
- R2: With `ce_n`=1 (standby), or with `ce_n`=0 and both `oe_n` and `we_n` high (output-disable), `dq_oe` is 0 whatever the other strobes are.
- R3: After reset the block is in array mode and every array byte reads 0xFF with no command issued.
- R4: A write outside a recognised sequence leaves array contents unchanged. An example is 0x00 written to any address while in array mode.
- R5: The sequence AA@0x555, 55@0x2AA, 90@0x555 enters identification mode. Only address bits 10:0 are compared. In this mode, reads return a value selected by addr[1:0]: 0x5A for 0, 0xC3 for 1, and 0x00 for 2 and 3.
- R6: A write of 0xF0 returns the block from identification mode to array reads.
- R7: The sequence AA@0x555, 55@0x2AA, A0@0x555 followed by a write of data D at address A starts a program. The operation lasts PROG_CYCLES clocks. While it runs, reads return a status byte with bit 7 = ~D[7], bit 6 flipping at every new read cycle, and bits 5:0 = 0. Once it ends, array reads resume.
- R8: A program sets the byte at A to old & D, so it can only clear bits.
- R9: The sequence AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, 30@A selects the sector given by A[18:16]. After a window of WIN_CYCLES clocks with no further 0x30 write, the erase runs for ERASE_CYCLES clocks. All bytes of the selected sectors then read 0xFF and other sectors are unchanged. During the window and the erase, the status byte has bit 7 = 0.
- R10: Each further 0x30 write inside the window adds its sector and restarts the window, so several sectors are erased together.
- R11: Replacing the final 30@A with 10@0x555 erases every sector.
- R12: Writes made while a program or erase runs are ignored, including 0xF0 and unlock cycles.
- R13: A write that breaks a sequence (wrong data or wrong unlock address) returns the block to array mode. Any following writes must then start the sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus, inbound half |
| dq_o | output | 8 | Data bus, outbound half (0 when not driven) |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions assume the following about the inputs:

- Strobes and address are steady across each clock edge.
- A write cycle is held for at least one full clock.
- Output enable is not pulsed with write enable in the same cycle except in the deliberate contention sweep.

The stimulus keeps within these limits by changing every input only on the falling clock edge. It also separates each bus cycle from the next by an idle clock, so every read and every write begins with a fresh strobe transition.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  localparam int BYTE_W = 8;
  localparam int UNLK_W = 11;

  localparam logic [UNLK_W-1:0] UNLK_ADDR_A = 11'h555;
  localparam logic [UNLK_W-1:0] UNLK_ADDR_B = 11'h2AA;

  localparam logic [BYTE_W-1:0] CMD_KEY_A   = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_KEY_B   = 8'h55;
  localparam logic [BYTE_W-1:0] CMD_IDENT   = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_PROGRAM = 8'hA0;
  localparam logic [BYTE_W-1:0] CMD_ER_SET  = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_ER_SECT = 8'h30;
  localparam logic [BYTE_W-1:0] CMD_ER_CHIP = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_EXIT    = 8'hF0;

  typedef enum logic [2:0] {
    CYC_STANDBY,
    CYC_OUTDIS,
    CYC_READ,
    CYC_WRITE,
    CYC_CONTEND
  } bus_cyc_e;

  typedef enum logic [3:0] {
    MD_ARRAY,
    MD_KEY1,
    MD_KEY2,
    MD_PROG_LOAD,
    MD_ER_KEY0,
    MD_ER_KEY1,
    MD_ER_CMD,
    MD_ER_WIN,
    MD_BUSY_PROG,
    MD_BUSY_ERASE,
    MD_IDENT
  } mode_e;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_IDENT,
    SRC_STATUS
  } rd_src_e;

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
  import flash_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     we_n,
  output bus_cyc_e cyc,
  output logic     wr_pulse,
  output logic     rd_start
);

  bus_cyc_e prev_cyc;

  always_comb begin
    if (ce_n) begin
      cyc = CYC_STANDBY;
    end else begin
      unique case ({oe_n, we_n})
        2'b01:   cyc = CYC_READ;
        2'b10:   cyc = CYC_WRITE;
        2'b11:   cyc = CYC_OUTDIS;
        default: cyc = CYC_CONTEND;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_cyc <= CYC_STANDBY;
    else        prev_cyc <= cyc;
  end

  assign wr_pulse = (cyc == CYC_WRITE) && (prev_cyc != CYC_WRITE);
  assign rd_start = (cyc == CYC_READ)  && (prev_cyc != CYC_READ);

  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R12

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_bus_pkg::*;
#(
  parameter int SECT_W       = 3,
  parameter int OFF_W        = 5,
  parameter int PROG_CYCLES  = 24,
  parameter int ERASE_CYCLES = 64,
  parameter int WIN_CYCLES   = 16
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_pulse,
  input  logic                       rd_start,
  input  logic [UNLK_W-1:0]          unlk_addr,
  input  logic [SECT_W+OFF_W-1:0]    wr_idx,
  input  logic [BYTE_W-1:0]          din,
  output rd_src_e                    rd_src,
  output logic [BYTE_W-1:0]          status,
  output logic                       prog_commit,
  output logic [SECT_W+OFF_W-1:0]    prog_idx,
  output logic [BYTE_W-1:0]          prog_data,
  output logic                       erase_commit,
  output logic [(1<<SECT_W)-1:0]     erase_mask
);

  localparam int IDX_W  = SECT_W + OFF_W;
  localparam int SECT_N = 1 << SECT_W;
  localparam int MAX_PE = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_MAX = (MAX_PE > WIN_CYCLES) ? MAX_PE : WIN_CYCLES;
  localparam int CNT_W  = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] LOAD_PROG = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_ER   = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] LOAD_WIN  = CNT_W'(WIN_CYCLES);

  mode_e                mode_q, mode_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [SECT_N-1:0]    mask_q, mask_d;
  logic [BYTE_W-1:0]    tgt_q, tgt_d;
  logic [IDX_W-1:0]     pidx_q, pidx_d;
  logic                 toggle_q;

  logic                 at_a, at_b;
  logic [SECT_N-1:0]    sect_hot;

  assign at_a     = (unlk_addr == UNLK_ADDR_A);
  assign at_b     = (unlk_addr == UNLK_ADDR_B);
  assign sect_hot = SECT_N'(1) << wr_idx[IDX_W-1 -: SECT_W];

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    mask_d = mask_q;
    tgt_d  = tgt_q;
    pidx_d = pidx_q;
    unique case (mode_q)
      MD_ARRAY: begin
        if (wr_pulse && at_a && din == CMD_KEY_A) mode_d = MD_KEY1;
      end
      MD_KEY1: begin
        if (wr_pulse) mode_d = (at_b && din == CMD_KEY_B) ? MD_KEY2 : MD_ARRAY;
      end
      MD_KEY2: begin
        if (wr_pulse) begin
          mode_d = MD_ARRAY;
          if (at_a) begin
            if (din == CMD_IDENT)   mode_d = MD_IDENT;
            if (din == CMD_PROGRAM) mode_d = MD_PROG_LOAD;
            if (din == CMD_ER_SET)  mode_d = MD_ER_KEY0;
          end
        end
      end
      MD_PROG_LOAD: begin
        if (wr_pulse) begin
          mode_d = MD_BUSY_PROG;
          cnt_d  = LOAD_PROG;
          tgt_d  = din;
          pidx_d = wr_idx;
        end
      end
      MD_ER_KEY0: begin
        if (wr_pulse) mode_d = (at_a && din == CMD_KEY_A) ? MD_ER_KEY1 : MD_ARRAY;
      end
      MD_ER_KEY1: begin
        if (wr_pulse) mode_d = (at_b && din == CMD_KEY_B) ? MD_ER_CMD : MD_ARRAY;
      end
      MD_ER_CMD: begin
        if (wr_pulse) begin
          tgt_d = '1;
          if (at_a && din == CMD_ER_CHIP) begin
            mode_d = MD_BUSY_ERASE;
            cnt_d  = LOAD_ER;
            mask_d = '1;
          end else if (din == CMD_ER_SECT) begin
            mode_d = MD_ER_WIN;
            cnt_d  = LOAD_WIN;
            mask_d = sect_hot;
          end else begin
            mode_d = MD_ARRAY;
          end
        end
      end
      MD_ER_WIN: begin
        if (wr_pulse && din == CMD_ER_SECT) begin
          mask_d = mask_q | sect_hot;
          cnt_d  = LOAD_WIN;
        end else if (cnt_q == CNT_ONE) begin
          mode_d = MD_BUSY_ERASE;
          cnt_d  = LOAD_ER;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      MD_BUSY_PROG, MD_BUSY_ERASE: begin
        if (cnt_q == CNT_ONE) mode_d = MD_ARRAY;
        else                  cnt_d  = cnt_q - CNT_ONE;
      end
      MD_IDENT: begin
        if (wr_pulse && din == CMD_EXIT) mode_d = MD_ARRAY;
      end
      default: mode_d = MD_ARRAY;
    endcase
    if (wr_pulse && din == CMD_EXIT &&
        (mode_q == MD_KEY1 || mode_q == MD_KEY2 ||
         mode_q == MD_ER_KEY0 || mode_q == MD_ER_KEY1 || mode_q == MD_ER_CMD))
      mode_d = MD_ARRAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_ARRAY;
      cnt_q    <= '0;
      mask_q   <= '0;
      tgt_q    <= '1;
      pidx_q   <= '0;
      toggle_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      mask_q <= mask_d;
      tgt_q  <= tgt_d;
      pidx_q <= pidx_d;
      if (rd_start && rd_src == SRC_STATUS) toggle_q <= ~toggle_q;
    end
  end

  always_comb begin
    unique case (mode_q)
      MD_IDENT:                             rd_src = SRC_IDENT;
      MD_ER_WIN, MD_BUSY_PROG, MD_BUSY_ERASE: rd_src = SRC_STATUS;
      default:                              rd_src = SRC_ARRAY;
    endcase
  end

  assign status       = {~tgt_q[BYTE_W-1], toggle_q, {(BYTE_W-2){1'b0}}};
  assign prog_commit  = (mode_q == MD_BUSY_PROG)  && (cnt_q == CNT_ONE);
  assign erase_commit = (mode_q == MD_BUSY_ERASE) && (cnt_q == CNT_ONE);
  assign prog_idx     = pidx_q;
  assign prog_data    = tgt_q;
  assign erase_mask   = mask_q;

  AST_PROG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q == MD_BUSY_PROG) |-> cnt_q == LOAD_PROG); // R7
  AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_BUSY_PROG || mode_q == MD_BUSY_ERASE) && cnt_q > CNT_ONE)
      |=> (mode_q == $past(mode_q)) && (cnt_q == $past(cnt_q) - CNT_ONE)); // R12
  AST_ERASE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MD_BUSY_ERASE && mode_q != MD_BUSY_ERASE) |-> mode_q == MD_ARRAY); // R9
  AST_WIN_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MD_ER_WIN) |-> ((mask_q & $past(mask_q)) == $past(mask_q))); // R10

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_bus_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter int OFF_W  = 5
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SECT_W+OFF_W-1:0] rd_idx,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic                    prog_commit,
  input  logic [SECT_W+OFF_W-1:0] prog_idx,
  input  logic [BYTE_W-1:0]       prog_data,
  input  logic                    erase_commit,
  input  logic [(1<<SECT_W)-1:0]  erase_mask
);

  localparam int IDX_W = SECT_W + OFF_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam int SECT_BYTES = 1 << OFF_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) cells[w] <= '1;
    end else begin
      for (int w = 0; w < DEPTH; w++) begin
        if (erase_commit && erase_mask[w / SECT_BYTES])
          cells[w] <= '1;
        else if (prog_commit && prog_idx == IDX_W'(w))
          cells[w] <= cells[w] & prog_data;
      end
    end
  end

  assign rd_data = cells[rd_idx];

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_commit && !erase_commit)
      |=> ((cells[$past(prog_idx)] | $past(cells[prog_idx])) == $past(cells[prog_idx]))); // R8

endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl
  import flash_bus_pkg::*;
#(
  parameter int          ADDR_W       = 19,
  parameter int          SECT_W       = 3,
  parameter int          OFF_W        = 5,
  parameter int          PROG_CYCLES  = 24,
  parameter int          ERASE_CYCLES = 64,
  parameter int          WIN_CYCLES   = 16,
  parameter logic [7:0]  MAKER_CODE   = 8'h5A,
  parameter logic [7:0]  PART_CODE    = 8'hC3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe
);

  localparam int IDX_W  = SECT_W + OFF_W;
  localparam int SECT_N = 1 << SECT_W;

  bus_cyc_e          cyc;
  logic              wr_pulse, rd_start;
  logic [IDX_W-1:0]  cell_idx;
  rd_src_e           rd_src;
  logic [BYTE_W-1:0] status, arr_data, id_data;
  logic              prog_commit, erase_commit;
  logic [IDX_W-1:0]  prog_idx;
  logic [BYTE_W-1:0] prog_data;
  logic [SECT_N-1:0] erase_mask;
  logic              unused_addr;

  assign cell_idx    = {addr[ADDR_W-1 -: SECT_W], addr[OFF_W-1:0]};
  assign unused_addr = ^addr;

  flash_bus_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .cyc      (cyc),
    .wr_pulse (wr_pulse),
    .rd_start (rd_start)
  );

  flash_cmd_fsm #(
    .SECT_W       (SECT_W),
    .OFF_W        (OFF_W),
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .WIN_CYCLES   (WIN_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_pulse     (wr_pulse),
    .rd_start     (rd_start),
    .unlk_addr    (addr[UNLK_W-1:0]),
    .wr_idx       (cell_idx),
    .din          (dq_i),
    .rd_src       (rd_src),
    .status       (status),
    .prog_commit  (prog_commit),
    .prog_idx     (prog_idx),
    .prog_data    (prog_data),
    .erase_commit (erase_commit),
    .erase_mask   (erase_mask)
  );

  flash_cell_array #(
    .SECT_W (SECT_W),
    .OFF_W  (OFF_W)
  ) u_cells (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (cell_idx),
    .rd_data      (arr_data),
    .prog_commit  (prog_commit),
    .prog_idx     (prog_idx),
    .prog_data    (prog_data),
    .erase_commit (erase_commit),
    .erase_mask   (erase_mask)
  );

  always_comb begin
    unique case (addr[1:0])
      2'd0:    id_data = MAKER_CODE;
      2'd1:    id_data = PART_CODE;
      default: id_data = '0;
    endcase
  end

  assign dq_oe = (cyc == CYC_READ);

  always_comb begin
    dq_o = '0;
    if (dq_oe) begin
      unique case (rd_src)
        SRC_IDENT:  dq_o = id_data;
        SRC_STATUS: dq_o = status;
        default:    dq_o = arr_data;
      endcase
    end
  end

  AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !dq_oe); // R1
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dq_oe && dq_o == '0)); // R2
  AST_COMMIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_commit && erase_commit)); // R12

endmodule

// File: tb/flash_bus_ctrl_bench.sv
module flash_bus_ctrl_bench;

  localparam int PROG  = 24;
  localparam int ERASE = 64;
  localparam int WIN   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [256];

  always #5 clk = ~clk;

  flash_bus_ctrl u_flash_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  function automatic int midx(logic [18:0] a);
    return int'({a[18:16], a[4:0]});
  endfunction

  function automatic logic [18:0] maddr(int i);
    logic [7:0] b;
    b = i[7:0];
    return {b[7:5], 11'h0, b[4:0]};
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; dq_i = d; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic bus_read(logic [18:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = dq_o;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic keys();
    bus_write(19'h00555, 8'hAA);
    bus_write(19'h002AA, 8'h55);
  endtask

  task automatic program_byte(logic [18:0] a, logic [7:0] d);
    keys();
    bus_write(19'h00555, 8'hA0);
    bus_write(a, d);
  endtask

  task automatic erase_prefix();
    keys();
    bus_write(19'h00555, 8'h80);
    keys();
  endtask

  task automatic verify_all(string tag);
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      bus_read(maddr(i), v);
      chk(v, model[i], tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s1, s2, d;
    logic [18:0] a;
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;

    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    @(negedge clk);
    chk({7'b0, dq_oe}, 8'h00, "R2 reset idle bus released");

    // R1 R2: sweep all strobe combinations
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      addr = 19'h30100; dq_i = 8'h00;
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      @(posedge clk);
      @(negedge clk);
      chk({7'b0, dq_oe}, (c == 1) ? 8'h01 : 8'h00, c[2] ? "R2 standby" : "R1 cycle decode");
      if (c == 1) chk(dq_o, 8'hFF, "R3 read during sweep");
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
      @(posedge clk);
    end

    // R3: reset contents
    verify_all("R3 erased after reset");

    // R4: stray write
    bus_write(19'h12345, 8'h00);
    bus_read(19'h12345, v);
    chk(v, 8'hFF, "R4 stray write ignored");
    bus_write(19'h00555, 8'h00);
    bus_read(19'h00555, v);
    chk(v, 8'hFF, "R4 stray write at unlock address");

    // R5 R6: identification mode
    keys();
    bus_write(19'h7F555, 8'h90);
    for (int k = 0; k < 8; k++) begin
      a = {k[2:0], 14'h0, k[1:0]};
      bus_read(a, v);
      chk(v, (k[1:0] == 2'd0) ? 8'h5A : (k[1:0] == 2'd1) ? 8'hC3 : 8'h00, "R5 ident code");
    end
    bus_write(19'h00000, 8'hF0);
    bus_read(19'h00000, v);
    chk(v, 8'hFF, "R6 exit to array");

    // R13: broken sequences
    bus_write(19'h00555, 8'hAA);
    bus_write(19'h002AA, 8'h12);
    bus_write(19'h00555, 8'h90);
    bus_read(19'h00000, v);
    chk(v, 8'hFF, "R13 wrong data aborts");
    bus_write(19'h00555, 8'hAA);
    bus_write(19'h00000, 8'hF0);
    bus_write(19'h002AA, 8'h55);
    bus_write(19'h00555, 8'h90);
    bus_read(19'h00001, v);
    chk(v, 8'hFF, "R13 exit aborts partial sequence");
    bus_write(19'h00555, 8'hAA);
    bus_write(19'h002AB, 8'h55);
    bus_write(19'h00555, 8'h90);
    bus_read(19'h00000, v);
    chk(v, 8'hFF, "R13 wrong unlock address aborts");

    // R7 R8: program sweep, two passes per sector
    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < 8; s++) begin
        a = {s[2:0], 11'h0, 5'(s * 3 + pass)};
        a = {a[18:16], 11'h0, a[4:0]};
        d = (pass == 0) ? (8'h3C ^ 8'(s * 8'h11)) : (8'hF5 - 8'(s * 5));
        program_byte(a, d);
        bus_read(a, s1);
        chk(s1 & 8'hBF, {~d[7], 7'b0}, "R7 status while programming");
        bus_read(a, s2);
        chk({7'b0, s1[6] ^ s2[6]}, 8'h01, "R7 toggle bit flips");
        idle(PROG + 4);
        model[midx(a)] = model[midx(a)] & d;
        bus_read(a, v);
        chk(v, model[midx(a)], "R8 program clears bits only");
      end
    end
    // R8: same address twice, second pass on sector 0 offset 0
    a = 19'h00000;
    program_byte(a, 8'hF0);
    idle(PROG + 4);
    program_byte(a, 8'h3F);
    idle(PROG + 4);
    model[0] = model[0] & 8'hF0 & 8'h3F;
    bus_read(a, v);
    chk(v, model[0], "R8 repeated program ANDs");
    verify_all("R8 array after programs");

    // R12: writes during busy are ignored
    a = 19'h3000A;
    program_byte(a, 8'h0F);
    bus_write(19'h00000, 8'hF0);
    bus_write(19'h00555, 8'hAA);
    bus_read(a, v);
    chk(v & 8'hBF, 8'h80, "R12 still busy after writes");
    idle(PROG + 4);
    model[midx(a)] = model[midx(a)] & 8'h0F;
    bus_read(a, v);
    chk(v, model[midx(a)], "R12 program unaffected");
    bus_write(19'h002AA, 8'h55);
    bus_write(19'h00555, 8'h90);
    bus_read(19'h00000, v);
    chk(v, model[0], "R12 unlock during busy dropped");

    // R9: single sector erase
    erase_prefix();
    bus_write(19'h20000, 8'h30);
    bus_read(19'h20000, v);
    chk(v & 8'hBF, 8'h00, "R9 erase status");
    idle(WIN + ERASE + 6);
    for (int i = 64; i < 96; i++) model[i] = 8'hFF;
    verify_all("R9 sector erase");

    // R10: two sectors within the window
    erase_prefix();
    bus_write(19'h10000, 8'h30);
    bus_read(19'h10000, v);
    chk(v & 8'hBF, 8'h00, "R10 window status");
    bus_write(19'h60000, 8'h30);
    idle(WIN + ERASE + 6);
    for (int i = 32; i < 64; i++) model[i] = 8'hFF;
    for (int i = 192; i < 224; i++) model[i] = 8'hFF;
    verify_all("R10 multi-sector erase");

    // R11: chip erase
    erase_prefix();
    bus_write(19'h00555, 8'h10);
    bus_read(19'h00000, v);
    chk(v & 8'hBF, 8'h00, "R11 chip erase status");
    idle(ERASE + 6);
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    verify_all("R11 chip erase");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule